// File: doc/BRIEF.md
# Serial-Bus Target for an Eight-Bit Port Expander

This block is the two-wire serial target that sits in front of the register bank of an eight-bit I/O expander. It runs on a fast system clock. It brings the bus clock and data lines into that clock domain, filters out short spikes, and detects START, repeated START and STOP conditions. It then answers a 7-bit address made of a fixed upper nibble and three strap pins.

After an acknowledged write address, the first byte loads a command pointer. Its two low bits pick one of four registers in the neighbouring bank. Every later byte in the same transfer becomes a one-cycle write strobe, with the data and the pointer as the index. A read address makes the block fetch the selected register through a one-cycle read strobe and shift it out MSB first. It fetches again for every byte the master acknowledges.

The pointer is kept across transfers. A master can therefore aim it once and then poll the same register with bare read transfers, and each byte carries a new sample. The data line is an open-drain enable: the block pulls the line low or leaves it released.

Top module: `i2c_expander_target`

## Requirements
- R1: The block answers only the address {0011, addr_strap[2:0]}, sent MSB first and followed by a direction bit (1 = read, 0 = write). On any other address it gives no acknowledge and raises no strobe until the next START.
- R2: A START (data falling while clock is high) in any state restarts address reception. A STOP (data rising while clock is high) returns the block to idle with the data line released. A transfer cut short by either produces no write strobe.
- R3: The block acknowledges a matching address and every byte it receives by asserting sda_oe (1 = pull data low) through the whole high phase of the ninth clock.
- R4: The first byte after a write address sets the command pointer from its two low bits, and the pointer appears on reg_idx. The upper six bits are ignored. The pointer keeps its value across STOP and START.
- R5: Each later byte of a write transfer gives exactly one one-cycle wr_stb with the byte on wr_data. Consecutive bytes all go to the same register.
- R6: A read transfer, directly or after a repeated START, returns the register that reg_idx selects, MSB first. Each byte is fetched with one one-cycle rd_stb, issued just before its first bit.
- R7: After a master acknowledge the block fetches and sends the next byte, a new sample of the same register. After a master not-acknowledge it releases the data line until the next START or STOP.
- R8: The block ignores pulses on either line that are shorter than FILT_CYC system clocks (default 3, i.e. 60 ns at 50 MHz), including a low spike on data while the clock is high.
- R9: A synchronous active-low reset clears the command pointer to 0, releases the data line, clears both strobes and returns the block to idle.
- R10: sda_oe changes only while the bus clock is low, except for the release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, as sampled from the pad |
| sda_i | input | 1 | Bus data line, as sampled from the pad |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |
| addr_strap | input | 3 | Low three address bits |
| reg_idx | output | 2 | Command pointer: the register index selected |
| wr_data | output | 8 | Byte to write; valid while wr_stb is high |
| wr_stb | output | 1 | One-cycle write strobe |
| rd_stb | output | 1 | One-cycle strobe; rd_data is taken in the same cycle |
| rd_data | input | 8 | Contents of the register that reg_idx selects |

## Verification
Most internal faults appear on sda_oe within the same bit. A wrong bit count or a wrong state moves or drops the acknowledge on the ninth clock, or places a read bit in the wrong slot. The reference model checks sda_oe during every high phase. A fault in the pointer or in the write path shows at the bank's ports at the end of the transfer: a wrong reg_idx, a wrong or missing wr_stb, or a byte stored in the wrong register.

// File: rtl/i2ct_pkg.sv
// Shared types for the serial expander target.
// Assumes: bytes are eight bits; the state encoding is internal to the FSM.
package i2ct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } tgt_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2ct_glitch_filter.sv
// Synchronizer plus persistence filter for one bus line.
// The output follows the input only after the synchronized input has
// differed from it for FILT_CYC consecutive clocks.
// Assumes: SYNC_STAGES >= 2, FILT_CYC >= 1, the idle bus level is high.
module i2ct_glitch_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   clean_q;
    logic                   synced;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign clean_o = clean_q;

    // Purpose: bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Purpose: accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_q <= 1'b1;
        end else if (synced == clean_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            run_q   <= '0;
            clean_q <= synced;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2ct_bus_cond.sv
// Turns the filtered clock and data levels into one-cycle events:
// clock rise, clock fall, START and STOP.
// Assumes: both inputs come through filters of equal latency.
module i2ct_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    // Purpose: remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_p;
    assign scl_fall  = ~scl_f & scl_p;
    assign start_det = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/i2ct_proto_fsm.sv
// Protocol engine: address match, command pointer, write and read bytes,
// acknowledge generation and master-acknowledge sampling.
// Input bits are taken on clock rise; sda_oe moves only on clock fall.
// Assumes: event inputs are one-cycle pulses; rd_data is valid in the
// cycle in which rd_stb would be raised.
module i2ct_proto_fsm
    import i2ct_pkg::*;
#(
    parameter logic [3:0]  ADDR_HI   = 4'b0011,
    parameter int unsigned REG_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_f,
    input  logic [2:0]           strap,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic                 sda_oe,
    output logic [REG_IDX_W-1:0] cmd_ptr,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 wr_stb,
    output logic                 rd_stb
);
    tgt_state_e           state;
    logic [BYTE_W-1:0]    shreg, tx;
    logic [2:0]           bitcnt;
    logic                 full, rw_q, match_q, ack_ok;
    logic [REG_IDX_W-1:0] cmd_q;
    logic                 oe_q, wr_q, rd_q;
    logic [BYTE_W-1:0]    wd_q;
    logic                 is_rx;
    logic [BYTE_W-1:0]    rx_byte;

    assign is_rx   = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
    assign rx_byte = {shreg[BYTE_W-2:0], sda_f};

    assign sda_oe  = oe_q;
    assign cmd_ptr = cmd_q;
    assign wr_data = wd_q;
    assign wr_stb  = wr_q;
    assign rd_stb  = rd_q;

    // Purpose: advance the transfer on bus events and drive the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            tx      <= '0;
            bitcnt  <= '0;
            full    <= 1'b0;
            rw_q    <= 1'b0;
            match_q <= 1'b0;
            ack_ok  <= 1'b0;
            cmd_q   <= '0;
            oe_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                full   <= 1'b0;
                oe_q   <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                full  <= 1'b0;
                oe_q  <= 1'b0;
            end else begin
                if (is_rx && scl_rise) begin
                    shreg  <= rx_byte;
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        full <= 1'b1;
                        if (state == ST_ADDR) begin
                            rw_q    <= sda_f;
                            match_q <= (rx_byte[7:1] == {ADDR_HI, strap});
                        end
                    end
                end
                if (state == ST_RDATA && scl_rise) begin
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) full <= 1'b1;
                end
                if (state == ST_RACK && scl_rise) ack_ok <= ~sda_f;
                if (scl_fall) begin
                    case (state)
                        ST_ADDR: if (full) begin
                            full <= 1'b0;
                            if (match_q) begin
                                oe_q  <= 1'b1;
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                        ST_CMD: if (full) begin
                            full  <= 1'b0;
                            cmd_q <= shreg[REG_IDX_W-1:0];
                            oe_q  <= 1'b1;
                            state <= ST_CMD_ACK;
                        end
                        ST_WDATA: if (full) begin
                            full  <= 1'b0;
                            wd_q  <= shreg;
                            wr_q  <= 1'b1;
                            oe_q  <= 1'b1;
                            state <= ST_WDATA_ACK;
                        end
                        ST_ADDR_ACK: begin
                            bitcnt <= '0;
                            if (rw_q) begin
                                tx    <= rd_data;
                                rd_q  <= 1'b1;
                                oe_q  <= ~rd_data[BYTE_W-1];
                                state <= ST_RDATA;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= ST_CMD;
                            end
                        end
                        ST_CMD_ACK, ST_WDATA_ACK: begin
                            bitcnt <= '0;
                            oe_q   <= 1'b0;
                            state  <= ST_WDATA;
                        end
                        ST_RDATA: begin
                            if (full) begin
                                full  <= 1'b0;
                                oe_q  <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                oe_q <= ~tx[3'd7 - bitcnt];
                            end
                        end
                        ST_RACK: begin
                            if (ack_ok) begin
                                bitcnt <= '0;
                                tx     <= rd_data;
                                rd_q   <= 1'b1;
                                oe_q   <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/i2c_expander_target.sv
// Top of the serial target: two line filters, the bus-event decoder and
// the protocol engine. reg_idx is the held command pointer.
// Assumes: clk is fast enough that FILT_CYC clocks are shorter than any
// legal bus phase; the pads resolve the open-drain enable.
module i2c_expander_target #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYC    = 3,
    parameter logic [3:0]  ADDR_HI     = 4'b0011,
    parameter int unsigned REG_IDX_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [2:0]           addr_strap,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [7:0]           wr_data,
    output logic                 wr_stb,
    output logic                 rd_stb,
    input  logic [7:0]           rd_data
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, clean_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_i, scl_i};
    assign scl_f     = clean_lines[0];
    assign sda_f     = clean_lines[1];

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2ct_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    i2ct_bus_cond cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2ct_proto_fsm #(
        .ADDR_HI  (ADDR_HI),
        .REG_IDX_W(REG_IDX_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_f    (sda_f),
        .strap    (addr_strap),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .cmd_ptr  (reg_idx),
        .wr_data  (wr_data),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb)
    );

endmodule

// File: rtl/i2ct_checker.sv
// Protocol properties of the serial target, bound into the top.
// Assumes: the filtered clock and the START/STOP events are visible.
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic wr_stb,
    input logic rd_stb
);
    AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R10
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R2
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R2
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb); // R6
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb)); // R5

endmodule

bind i2c_expander_target i2ct_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb)
);

// File: tb/i2c_expander_target_tb_top.sv
// Bench: a behavioural bus master with a bit-level reference for the
// target's data-line enable, compared on every clock of each high phase,
// plus a behavioural register bank at the strobe interface.
module i2c_expander_target_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
    logic sda_oe, wr_stb, rd_stb;
    logic [1:0] reg_idx;
    logic [7:0] wr_data, rd_data;
    logic [2:0] strap = 3'b101;
    logic scl_in, sda_in;

    int vectors = 0, miscompares = 0, wr_cnt = 0, rd_cnt = 0;
    logic chk_en = 1'b0, exp_oe = 1'b0, bad = 1'b0, bad_val = 1'b0, done = 1'b0;

    logic [7:0] bank [4] = '{8'h00, 8'h11, 8'h22, 8'h33};
    logic [7:0] port_val = 8'h3C;
    logic [7:0] mdl [4] = '{8'h00, 8'h11, 8'h22, 8'h33};

    localparam logic [7:0] AW = 8'h3A, AR = 8'h3B;

    always #10 clk = ~clk;

    assign scl_in  = m_scl | scl_gl;
    assign sda_in  = m_sda & ~sda_oe & ~sda_gl;
    assign rd_data = (reg_idx == 2'd0) ? port_val : bank[reg_idx];

    i2c_expander_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
        .sda_oe(sda_oe), .addr_strap(strap), .reg_idx(reg_idx),
        .wr_data(wr_data), .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    // Register bank: index 0 is the read-only input port, resampled per fetch.
    always @(posedge clk) begin
        if (wr_stb) begin
            wr_cnt <= wr_cnt + 1;
            if (reg_idx != 2'd0) bank[reg_idx] <= wr_data;
        end
        if (rd_stb) begin
            rd_cnt <= rd_cnt + 1;
            if (reg_idx == 2'd0) port_val <= port_val + 8'h11;
        end
    end

    // Per-clock comparison of the enable against the reference bit.
    always @(negedge clk) begin
        if (chk_en && (sda_oe !== exp_oe)) begin
            bad = 1'b1;
            bad_val = sda_oe;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One bus clock: gl=1 spikes SCL in the low phase, gl=2 spikes SDA low in the high phase.
    task automatic bit_x(input logic mb, input logic eo, input int gl, input string tag);
        step(5);
        m_sda = mb;
        if (gl == 1) begin step(6); scl_gl = 1'b1; step(2); scl_gl = 1'b0; step(12); end
        else step(20);
        exp_oe = eo; bad = 1'b0; bad_val = eo;
        m_scl = 1'b1; chk_en = 1'b1;
        if (gl == 2) begin step(10); sda_gl = 1'b1; step(2); sda_gl = 1'b0; step(13); end
        else step(25);
        chk_en = 1'b0;
        chk(!bad, tag, 32'(bad_val), 32'(eo));
        m_scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack, input string tag,
                           input int gl_scl_bit = -1, input int gl_sda_bit = -1);
        for (int i = 0; i < 8; i++)
            bit_x(b[7-i], 1'b0, (i == gl_scl_bit) ? 1 : (i == gl_sda_bit) ? 2 : 0, tag);
        bit_x(1'b1, ack, 0, {tag, " ack"});
    endtask

    task automatic rd_byte(input logic [7:0] e, input logic m_ack, input string tag);
        for (int i = 0; i < 8; i++) bit_x(1'b1, ~e[7-i], 0, tag);
        bit_x(~m_ack, 1'b0, 0, {tag, " master-ack"});
    endtask

    task automatic start_c;
        if (!m_scl) begin step(5); m_sda = 1'b1; step(20); m_scl = 1'b1; step(20); end
        m_sda = 1'b0; step(20); m_scl = 1'b0;
    endtask

    task automatic stop_c;
        step(5); m_sda = 1'b0; step(20); m_scl = 1'b1; step(20); m_sda = 1'b1; step(30);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w0, r0;
        logic [7:0] s0, s1, s2;
        step(5); rst_n = 1'b1; step(10);
        // R9: reset state
        chk(!sda_oe && !wr_stb && !rd_stb, "R9 idle outputs", {sda_oe, wr_stb, rd_stb}, 0);
        chk(reg_idx == 2'd0, "R9 pointer reset", reg_idx, 0);

        // R4 R6: read with the reset pointer returns the input port
        start_c(); wr_byte(AR, 1'b1, "R1 read address");
        rd_byte(port_val, 1'b0, "R6 default pointer read"); stop_c();

        // R4 R5: command 2 then one byte; upper command bits ignored
        w0 = wr_cnt;
        start_c(); wr_byte(AW, 1'b1, "R3 write address");
        wr_byte(8'hFE, 1'b1, "R3 command ack"); wr_byte(8'hA5, 1'b1, "R3 data ack"); stop_c();
        mdl[2] = 8'hA5;
        chk(reg_idx == 2'd2, "R4 pointer from low bits", reg_idx, 2);
        chk(bank[2] == mdl[2], "R5 write reg2", bank[2], mdl[2]);
        chk(wr_cnt - w0 == 1, "R5 one strobe per byte", wr_cnt - w0, 1);

        // R5: two bytes to register 3
        w0 = wr_cnt;
        start_c(); wr_byte(AW, 1'b1, "R3 write address");
        wr_byte(8'h03, 1'b1, "R4 command"); wr_byte(8'h5A, 1'b1, "R5 byte1");
        wr_byte(8'hC3, 1'b1, "R5 byte2"); stop_c();
        mdl[3] = 8'hC3;
        chk(bank[3] == mdl[3], "R5 same register twice", bank[3], mdl[3]);
        chk(wr_cnt - w0 == 2, "R5 two strobes", wr_cnt - w0, 2);

        // R6 R7: aim at reg 2 then repeated START read, ACK then NACK
        r0 = rd_cnt;
        start_c(); wr_byte(AW, 1'b1, "R3 write address"); wr_byte(8'h02, 1'b1, "R4 command");
        start_c(); wr_byte(AR, 1'b1, "R6 read after restart");
        rd_byte(mdl[2], 1'b1, "R6 reg2 byte1"); rd_byte(mdl[2], 1'b0, "R7 reg2 byte2");
        bit_x(1'b1, 1'b0, 0, "R7 released after nack");
        stop_c();
        chk(rd_cnt - r0 == 2, "R6 one fetch per byte", rd_cnt - r0, 2);

        // R4 R7: pointer 0 kept across transfers; fresh samples per byte
        start_c(); wr_byte(AW, 1'b1, "R3 write address"); wr_byte(8'h00, 1'b1, "R4 command"); stop_c();
        r0 = rd_cnt;
        start_c(); wr_byte(AR, 1'b1, "R1 read address");
        s0 = port_val; rd_byte(port_val, 1'b1, "R7 sample1");
        s1 = port_val; rd_byte(port_val, 1'b1, "R7 sample2");
        s2 = port_val; rd_byte(port_val, 1'b0, "R7 sample3"); stop_c();
        chk(rd_cnt - r0 == 3, "R7 three fetches", rd_cnt - r0, 3);
        chk(s0 != s1 && s1 != s2, "R7 samples differ", {s0, s1}, {s0, s0 + 8'h11});

        // R1: wrong strap bits and wrong upper nibble are ignored
        w0 = wr_cnt;
        start_c(); wr_byte(8'h32, 1'b0, "R1 strap mismatch");
        wr_byte(8'h01, 1'b0, "R1 no ack"); wr_byte(8'hEE, 1'b0, "R1 no ack"); stop_c();
        start_c(); wr_byte(8'h5A, 1'b0, "R1 nibble mismatch"); wr_byte(8'h01, 1'b0, "R1 no ack"); stop_c();
        chk(wr_cnt == w0, "R1 no strobe", wr_cnt - w0, 0);
        chk(reg_idx == 2'd0, "R1 pointer untouched", reg_idx, 0);

        // R8: spikes on SCL (low phase) and SDA (high phase) inside a write
        start_c(); wr_byte(AW, 1'b1, "R3 write address"); wr_byte(8'h01, 1'b1, "R4 command");
        wr_byte(8'h96, 1'b1, "R8 spiked byte", 2, 0); stop_c();
        mdl[1] = 8'h96;
        chk(bank[1] == mdl[1], "R8 spikes ignored", bank[1], mdl[1]);

        // R2: START mid data byte aborts; STOP mid address goes idle
        w0 = wr_cnt;
        start_c(); wr_byte(AW, 1'b1, "R3 write address"); wr_byte(8'h01, 1'b1, "R4 command");
        for (int i = 0; i < 4; i++) bit_x(1'b0, 1'b0, 0, "R2 partial byte");
        start_c(); for (int i = 0; i < 3; i++) bit_x(1'b0, 1'b0, 0, "R2 partial address");
        stop_c();
        chk(wr_cnt == w0 && bank[1] == mdl[1], "R2 aborted write", bank[1], mdl[1]);
        chk(!sda_oe, "R2 idle after stop", sda_oe, 0);
        start_c(); wr_byte(AW, 1'b1, "R2 recovers"); wr_byte(8'h01, 1'b1, "R4 command");
        wr_byte(8'h77, 1'b1, "R5 data"); stop_c();
        mdl[1] = 8'h77;
        chk(bank[1] == mdl[1], "R2 write after abort", bank[1], mdl[1]);

        // R9: reset mid-transfer clears the pointer and releases the line
        start_c(); wr_byte(AW, 1'b1, "R3 write address"); wr_byte(8'h03, 1'b1, "R4 command");
        step(3); rst_n = 1'b0; step(3);
        chk(reg_idx == 2'd0 && !sda_oe, "R9 reset mid-transfer", {reg_idx, sda_oe}, 0);
        rst_n = 1'b1; step(20); stop_c();
        start_c(); wr_byte(AR, 1'b1, "R9 read after reset");
        rd_byte(port_val, 1'b0, "R9 pointer back to port"); stop_c();
        chk(bank[3] == mdl[3], "R9 bank intact", bank[3], mdl[3]);

        finish_run();
    end

endmodule